// File: doc/BRIEF.md
# Transmit Descriptor List Pointer and End-of-List Poller

This block keeps the physical address of the transmit frame descriptor that the DMA engine is working on. It also decides when the engine re-reads the next-pointer field of that descriptor once the end of the list has been reached. A host register port loads two registers: a 32-bit list pointer and a poll period. The list pointer always holds an 8-byte-aligned address. A value of zero means no frames remain. The host may only load the pointer while it is zero, so an active list cannot be redirected under the engine.

The engine reports each next-pointer value it fetches. A non-zero value moves the list pointer to the next descriptor. A zero value starts the poll timer. A prescaler turns `CYC_PER_TICK` clock cycles into one 320 ns tick. The timer emits a one-cycle `fetch_pulse` once every `poll_period` ticks, until a non-zero next pointer arrives or the list pointer becomes zero. A halt input freezes all engine-side activity. The engine can also load the pointer directly through an update port, for example to clear it at the end of the list.

Top module: `txd_list_poller`

## Requirements
- R1: After reset, `list_ptr` is 0, `list_empty` is 1, `poll_period` is 0, and `poll_wait` and `fetch_pulse` are 0.
- R2: A host write with `host_wr_sel`=0 (pointer), made while `list_ptr` is 0, loads `host_wr_data` with bits [2:0] forced to zero. The new value is visible one cycle later.
- R3: A host pointer write made while `list_ptr` is non-zero is discarded, and `list_ptr` keeps its value.
- R4: A host write with `host_wr_sel`=1 (period) loads bits [6:0] of `host_wr_data` into `poll_period`. Bit 7 and all higher bits are ignored, so writing 0xFF reads back as 127.
- R5: A non-halted `nxt_valid` with a next pointer that is non-zero after alignment loads `list_ptr` with that pointer, bits [2:0] cleared. It also clears `poll_wait`, and no further `fetch_pulse` follows.
- R6: A non-halted `nxt_valid` with a zero next pointer, while `list_ptr` is non-zero, sets `poll_wait`. `fetch_pulse` then rises for one cycle exactly `CYC_PER_TICK`×`poll_period` cycles after that cycle's edge, and again at the same interval after every pulse.
- R7: While `poll_period` is 0, no `fetch_pulse` is produced.
- R8: While `halt` is 1, no `fetch_pulse` occurs, `nxt_valid` and `eng_upd_valid` have no effect, and the poll counters hold their count. Counting resumes where it stopped when `halt` returns to 0.
- R9: A period write restarts the poll interval. The next pulse comes `CYC_PER_TICK`×(new period) cycles after the write edge.
- R10: A non-halted `eng_upd_valid` loads `eng_upd_ptr` with bits [2:0] cleared. A zero result clears `poll_wait`. No `fetch_pulse` occurs and no polling is armed while `list_ptr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_wr_sel | input | 1 | Write target: 0 list pointer, 1 poll period |
| host_wr_data | input | 32 | Host write data |
| halt | input | 1 | Freezes polling and engine-side pointer updates |
| eng_upd_valid | input | 1 | Engine pointer update strobe |
| eng_upd_ptr | input | 32 | Engine pointer update value |
| nxt_valid | input | 1 | Fetched next-pointer field is valid |
| nxt_ptr | input | 32 | Fetched next-pointer value |
| list_ptr | output | 32 | Current descriptor address, 8-byte aligned |
| list_empty | output | 1 | High while the list pointer is zero |
| poll_period | output | 7 | Poll interval in 320 ns ticks |
| poll_wait | output | 1 | Waiting at the end of the list for a non-zero next pointer |
| fetch_pulse | output | 1 | One-cycle request to re-read the next-pointer field |

## Verification
The assertions assume three things about the inputs. `CYC_PER_TICK` is at least 2. The engine raises `nxt_valid` only as the answer to a fetch it started. Every strobe lasts one cycle. The stimulus follows these rules. Every strobe is driven for exactly one cycle between falling edges. `nxt_valid` with a zero value is given only once per arming, and a non-zero answer ends the wait. Halt windows are opened and closed on falling edges, so the number of frozen cycles is known exactly and the resumed pulse time can be predicted.

// File: rtl/txd_pkg.sv
// Shared constants and types for the transmit descriptor list poller.
// Assumes descriptors are aligned on 8-byte boundaries.
package txd_pkg;
    localparam int ALIGN_BITS  = 3;
    localparam int PERIOD_IN_W = 8;

    typedef enum logic {
        WSEL_PTR    = 1'b0,
        WSEL_PERIOD = 1'b1
    } wsel_e;
endpackage

// File: rtl/txd_ptr_reg.sv
// List pointer register.
// Holds the aligned address of the current descriptor. Three sources can load it,
// in priority order: a host load (only while the pointer is zero), an advance to a
// fetched next pointer, and an engine-side update. The caller has already applied
// halt gating to the advance and update strobes.
module txd_ptr_reg
    import txd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_ld,
    input  logic [ADDR_W-1:0] host_val,
    input  logic              adv_ld,
    input  logic [ADDR_W-1:0] adv_val,
    input  logic              eng_ld,
    input  logic [ADDR_W-1:0] eng_val,
    output logic [ADDR_W-1:0] ptr,
    output logic              ptr_zero
);
    localparam int HI_W = ADDR_W - ALIGN_BITS;

    logic [HI_W-1:0] ptr_hi;
    logic [3*ALIGN_BITS-1:0] unused_low;

    assign unused_low = {host_val[ALIGN_BITS-1:0], adv_val[ALIGN_BITS-1:0],
                         eng_val[ALIGN_BITS-1:0]};

    // Pointer update, applied in priority order; the low bits are never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_hi <= '0;
        end else if (host_ld && (ptr_hi == '0)) begin
            ptr_hi <= host_val[ADDR_W-1:ALIGN_BITS];
        end else if (adv_ld) begin
            ptr_hi <= adv_val[ADDR_W-1:ALIGN_BITS];
        end else if (eng_ld) begin
            ptr_hi <= eng_val[ADDR_W-1:ALIGN_BITS];
        end
    end

    assign ptr      = {ptr_hi, {ALIGN_BITS{1'b0}}};
    assign ptr_zero = (ptr_hi == '0);
endmodule

// File: rtl/txd_period_reg.sv
// Poll period register.
// Keeps the low PER_W bits of the written byte. The bits above them, including
// the top bit, are dropped.
module txd_period_reg #(
    parameter int PER_W = 7,
    parameter int IN_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [IN_W-1:0]  data,
    output logic [PER_W-1:0] period
);
    logic [IN_W-PER_W-1:0] unused_hi;
    assign unused_hi = data[IN_W-1:PER_W];

    // Load the period on a host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= '0;
        end else if (wr) begin
            period <= data[PER_W-1:0];
        end
    end
endmodule

// File: rtl/txd_tick_gen.sv
// 320 ns tick prescaler.
// Counts CYC_PER_TICK cycles while run is high and holds its count while run is low.
// tick is high in the last cycle of each span. clear restarts the span; tick does
// not depend on clear, so no combinational loop forms through the timer.
module txd_tick_gen #(
    parameter int CYC_PER_TICK = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);
    localparam int CW = (CYC_PER_TICK > 1) ? $clog2(CYC_PER_TICK) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_TICK - 1);

    logic [CW-1:0] cnt;

    // Cycle count within the current tick span.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/txd_poll_timer.sv
// End-of-list poll timer.
// Tracks whether the engine is waiting on a zero next pointer and counts ticks
// up to the poll period. When the count reaches the period it issues a registered
// one-cycle fetch pulse. Assumes arm is only raised while the timer is not waiting.
module txd_poll_timer #(
    parameter int PER_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             disarm,
    input  logic             restart,
    input  logic             halt,
    input  logic             ptr_zero,
    input  logic [PER_W-1:0] period,
    input  logic             tick,
    output logic             run,
    output logic             pre_clear,
    output logic             waiting,
    output logic             fetch_pulse
);
    logic [PER_W-1:0] tcnt;
    logic             fire;

    assign run       = waiting && !halt && !ptr_zero && !disarm && (period != '0);
    assign fire      = tick && !restart && (tcnt == PER_W'(period - 1'b1));
    assign pre_clear = arm || restart || disarm || fire;

    // Waiting flag: set on a zero next pointer, dropped when the wait ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting <= 1'b0;
        end else if (disarm) begin
            waiting <= 1'b0;
        end else if (arm) begin
            waiting <= 1'b1;
        end
    end

    // Tick count within the current poll interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt <= '0;
        end else if (pre_clear) begin
            tcnt <= '0;
        end else if (tick) begin
            tcnt <= tcnt + 1'b1;
        end
    end

    // Registered fetch request, high for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_pulse <= 1'b0;
        end else begin
            fetch_pulse <= fire;
        end
    end
endmodule

// File: rtl/txd_list_poller.sv
// Transmit descriptor list pointer and end-of-list poller (top).
// Decodes host writes, gates the engine-side strobes with halt, and connects the
// pointer register, the period register, the prescaler and the poll timer.
// Assumes ADDR_W >= 8, and that every strobe is a single-cycle pulse.
module txd_list_poller
    import txd_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int PER_W        = 7,
    parameter int CYC_PER_TICK = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic              host_wr_sel,
    input  logic [ADDR_W-1:0] host_wr_data,
    input  logic              halt,
    input  logic              eng_upd_valid,
    input  logic [ADDR_W-1:0] eng_upd_ptr,
    input  logic              nxt_valid,
    input  logic [ADDR_W-1:0] nxt_ptr,
    output logic [ADDR_W-1:0] list_ptr,
    output logic              list_empty,
    output logic [PER_W-1:0]  poll_period,
    output logic              poll_wait,
    output logic              fetch_pulse
);
    logic wr_ptr, wr_per;
    logic nxt_hit, nxt_zero, adv_ld, eng_ld, eng_zero;
    logic arm, disarm;
    logic ptr_zero;
    logic run, pre_clear, tick;
    logic [ADDR_W-PERIOD_IN_W-1:0] unused_wr_hi;

    assign unused_wr_hi = host_wr_data[ADDR_W-1:PERIOD_IN_W];

    assign wr_ptr   = host_wr_en && (host_wr_sel == WSEL_PTR);
    assign wr_per   = host_wr_en && (host_wr_sel == WSEL_PERIOD);
    assign nxt_hit  = nxt_valid && !halt;
    assign nxt_zero = (nxt_ptr[ADDR_W-1:ALIGN_BITS] == '0);
    assign adv_ld   = nxt_hit && !nxt_zero;
    assign eng_ld   = eng_upd_valid && !halt;
    assign eng_zero = (eng_upd_ptr[ADDR_W-1:ALIGN_BITS] == '0);
    assign arm      = nxt_hit && nxt_zero && !ptr_zero && !poll_wait;
    assign disarm   = adv_ld || (eng_ld && eng_zero) || ptr_zero;

    txd_ptr_reg #(.ADDR_W(ADDR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_ld  (wr_ptr),
        .host_val (host_wr_data),
        .adv_ld   (adv_ld),
        .adv_val  (nxt_ptr),
        .eng_ld   (eng_ld),
        .eng_val  (eng_upd_ptr),
        .ptr      (list_ptr),
        .ptr_zero (ptr_zero)
    );

    txd_period_reg #(.PER_W(PER_W), .IN_W(PERIOD_IN_W)) u_per (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_per),
        .data   (host_wr_data[PERIOD_IN_W-1:0]),
        .period (poll_period)
    );

    txd_tick_gen #(.CYC_PER_TICK(CYC_PER_TICK)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clear (pre_clear),
        .tick  (tick)
    );

    txd_poll_timer #(.PER_W(PER_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         (arm),
        .disarm      (disarm),
        .restart     (wr_per),
        .halt        (halt),
        .ptr_zero    (ptr_zero),
        .period      (poll_period),
        .tick        (tick),
        .run         (run),
        .pre_clear   (pre_clear),
        .waiting     (poll_wait),
        .fetch_pulse (fetch_pulse)
    );

    assign list_empty = ptr_zero;
endmodule

// File: rtl/txd_list_poller_chk.sv
// Property checker for txd_list_poller, attached to it with a bind statement.
// Assumes single-cycle strobes and CYC_PER_TICK >= 2 for the pulse-width check.
module txd_list_poller_chk #(
    parameter int ADDR_W       = 32,
    parameter int PER_W        = 7,
    parameter int CYC_PER_TICK = 80
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr_en,
    input logic              host_wr_sel,
    input logic [ADDR_W-1:0] host_wr_data,
    input logic              halt,
    input logic              eng_upd_valid,
    input logic              nxt_valid,
    input logic [ADDR_W-1:0] nxt_ptr,
    input logic [ADDR_W-1:0] list_ptr,
    input logic [PER_W-1:0]  poll_period,
    input logic              poll_wait,
    input logic              fetch_pulse
);
    // R2: the pointer never holds an unaligned address.
    always_comb begin
        if (rst_n) begin
            assert_aligned_R2: assert (list_ptr[2:0] == 3'b000);
        end
    end

    assert_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (list_ptr != '0 && !((nxt_valid || eng_upd_valid) && !halt)) |=> $stable(list_ptr));

    assert_period_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && host_wr_sel) |=> (poll_period == $past(host_wr_data[PER_W-1:0])));

    assert_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_valid && !halt && list_ptr != '0 && nxt_ptr[ADDR_W-1:3] != '0)
        |=> (list_ptr == {$past(nxt_ptr[ADDR_W-1:3]), 3'b000} && !poll_wait));

    assert_no_poll_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_period == '0) |=> !fetch_pulse);

    assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !fetch_pulse);

    assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && list_ptr != '0) |=> $stable(list_ptr));

    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && host_wr_sel) |=> !fetch_pulse);

    assert_empty_no_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_pulse |-> (list_ptr != '0 && poll_wait));

    generate
        if (CYC_PER_TICK > 1) begin : g_width
            assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
                fetch_pulse |=> !fetch_pulse);
        end
    endgenerate
endmodule

bind txd_list_poller txd_list_poller_chk #(
    .ADDR_W(ADDR_W), .PER_W(PER_W), .CYC_PER_TICK(CYC_PER_TICK)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_wr_en    (host_wr_en),
    .host_wr_sel   (host_wr_sel),
    .host_wr_data  (host_wr_data),
    .halt          (halt),
    .eng_upd_valid (eng_upd_valid),
    .nxt_valid     (nxt_valid),
    .nxt_ptr       (nxt_ptr),
    .list_ptr      (list_ptr),
    .poll_period   (poll_period),
    .poll_wait     (poll_wait),
    .fetch_pulse   (fetch_pulse)
);

// File: tb/txd_list_poller_test.sv
`timescale 1ns/1ps
// Scoreboard bench for txd_list_poller.
// Driver tasks push expected register values into a queue, and a monitor pops and
// compares them on falling edges. Pulse timing is measured in falling edges.
module txd_list_poller_test;
    localparam int CYC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic        host_wr_sel = 1'b0;
    logic [31:0] host_wr_data = '0;
    logic        halt = 1'b0;
    logic        eng_upd_valid = 1'b0;
    logic [31:0] eng_upd_ptr = '0;
    logic        nxt_valid = 1'b0;
    logic [31:0] nxt_ptr = '0;
    logic [31:0] list_ptr;
    logic        list_empty;
    logic [6:0]  poll_period;
    logic        poll_wait;
    logic        fetch_pulse;

    int checks = 0;
    int fails = 0;
    int pulse_cnt = 0;
    bit done = 1'b0;

    typedef struct {
        int          sig;
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    txd_list_poller #(.CYC_PER_TICK(CYC)) uut (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_sel(host_wr_sel),
        .host_wr_data(host_wr_data), .halt(halt), .eng_upd_valid(eng_upd_valid),
        .eng_upd_ptr(eng_upd_ptr), .nxt_valid(nxt_valid), .nxt_ptr(nxt_ptr),
        .list_ptr(list_ptr), .list_empty(list_empty), .poll_period(poll_period),
        .poll_wait(poll_wait), .fetch_pulse(fetch_pulse)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: compare queued expectations on each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                exp_t e;
                logic [31:0] a;
                e = exp_q.pop_front();
                case (e.sig)
                    0: a = list_ptr;
                    1: a = {25'd0, poll_period};
                    2: a = {31'd0, poll_wait};
                    default: a = {31'd0, list_empty};
                endcase
                check(e.tag, a, e.val);
            end
        end
    end

    always @(negedge clk) if (fetch_pulse) pulse_cnt++;

    task automatic expect_sig(input int sig, input logic [31:0] val, input string tag);
        exp_q.push_back('{sig, val, tag});
    endtask

    task automatic host_wr(input logic sel, input logic [31:0] data);
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_sel = sel; host_wr_data = data;
        @(posedge clk); #1;
        host_wr_en = 1'b0;
    endtask

    task automatic give_next(input logic [31:0] val);
        @(negedge clk);
        nxt_valid = 1'b1; nxt_ptr = val;
        @(posedge clk); #1;
        nxt_valid = 1'b0;
    endtask

    task automatic eng_upd(input logic [31:0] val);
        @(negedge clk);
        eng_upd_valid = 1'b1; eng_upd_ptr = val;
        @(posedge clk); #1;
        eng_upd_valid = 1'b0;
    endtask

    task automatic measure(input int start, input int exp, input string tag);
        int n = start;
        do begin
            @(negedge clk);
            n++;
        end while (!fetch_pulse && n < 500);
        check(tag, n, exp);
    endtask

    task automatic no_pulse(input int cycles, input string tag);
        int p0 = pulse_cnt;
        repeat (cycles) @(negedge clk);
        check(tag, pulse_cnt - p0, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset ptr", list_ptr, 32'h0);
        check("R1 reset empty", {31'd0, list_empty}, 32'h1);
        check("R1 reset period", {25'd0, poll_period}, 32'h0);
        check("R1 reset wait/pulse", {30'd0, poll_wait, fetch_pulse}, 32'h0);

        host_wr(1'b0, 32'h0000_1007);
        expect_sig(0, 32'h0000_1000, "R2 aligned load");
        host_wr(1'b0, 32'h0000_2000);
        expect_sig(0, 32'h0000_1000, "R3 write discarded");
        host_wr(1'b1, 32'h0000_00FF);
        expect_sig(1, 32'd127, "R4 bit7 ignored");
        host_wr(1'b1, 32'h0000_0003);
        expect_sig(1, 32'd3, "R4 period 3");

        give_next(32'h0);
        expect_sig(2, 32'h1, "R6 wait armed");
        measure(-1, CYC * 3, "R6 first interval");
        measure(0, CYC * 3, "R6 repeat interval");

        give_next(32'h0000_300F);
        expect_sig(0, 32'h0000_3008, "R5 advance");
        expect_sig(2, 32'h0, "R5 wait cleared");
        no_pulse(30, "R5 polling stopped");

        host_wr(1'b1, 32'h0);
        give_next(32'h0);
        no_pulse(40, "R7 period zero");
        host_wr(1'b1, 32'h2);
        measure(-1, CYC * 2, "R9 restart period 2");
        repeat (3) @(negedge clk);
        host_wr(1'b1, 32'h5);
        measure(-1, CYC * 5, "R9 restart mid interval");

        // R8: freeze for exactly 20 cycles inside a 12-cycle interval.
        host_wr(1'b1, 32'h3);
        begin
            int p0;
            repeat (5) @(negedge clk);
            halt = 1'b1;
            p0 = pulse_cnt;
            repeat (3) @(negedge clk);
            nxt_valid = 1'b1; nxt_ptr = 32'h5000;
            eng_upd_valid = 1'b1; eng_upd_ptr = 32'h6000;
            @(negedge clk);
            nxt_valid = 1'b0; eng_upd_valid = 1'b0;
            repeat (16) @(negedge clk);
            check("R8 no pulse in halt", pulse_cnt - p0, 0);
            check("R8 ptr held in halt", list_ptr, 32'h0000_3008);
            halt = 1'b0;
            measure(24, CYC * 3 + 20, "R8 count resumes");
        end

        eng_upd(32'h0000_0005);
        expect_sig(0, 32'h0, "R10 engine clears ptr");
        expect_sig(2, 32'h0, "R10 wait dropped");
        no_pulse(40, "R10 no fetch when empty");
        give_next(32'h0);
        expect_sig(2, 32'h0, "R10 no arm when empty");
        host_wr(1'b0, 32'h0000_0047);
        expect_sig(0, 32'h0000_0040, "R2 reload after empty");
        eng_upd(32'h0000_0085);
        expect_sig(0, 32'h0000_0080, "R10 engine load aligned");
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule